// File: doc/BRIEF.md
# Ethernet receive frame validator

This block screens the receive side of a small Ethernet/IP endpoint that answers requests and never starts traffic. It watches a byte-wide receive stream with a start marker, an end marker and a valid flag. As the bytes go past it checks the frame check sequence, the frame length, the link and network addresses, the fixed header fields of ARP, IPv4, ICMP and UDP, and the IPv4 header and ICMP checksums. The frame contents are never stored.

One cycle after the last byte of a frame, the block raises a single-cycle strobe. The strobe carries a class code and, for UDP, the index of the local service port that the datagram targets. A reply builder downstream uses the class to decide what to send. It drops every frame that is marked as rejected. The node's MAC and IP addresses come in as static inputs. The service port table is held inside the block: it loads defaults at reset and can be rewritten at run time through a simple write port.

Top module: `frame_screen`

## Requirements
- R1: The CRC register starts at all ones and is updated LSB first with the reflected polynomial 0xEDB88320 over every byte from offset 0 through the last FCS byte. A frame is accepted only if the register then holds 0xDEBB20E3.
- R2: A frame longer than MAX_FRAME bytes (default 1536, FCS included) is class 0. There is no minimum length, so a 46-byte ARP request with no padding is accepted.
- R3: A frame whose source MAC (bytes 6..11) has bit 0 of byte 6 set is class 0.
- R4: The class is 1 (ARP) when all of these hold: type field (bytes 12..13) is 0x0806, hardware type is 1, protocol type is 0x0800, address lengths are 6 and 4, operation is 1, and the target protocol address (bytes 38..41) equals my_ip. The destination MAC and the embedded hardware addresses are ignored.
- R5: A frame passes the IPv4 base rules only when all of these hold: destination MAC equals my_mac, type is 0x0800, byte 14 is 0x45, the MF bit and fragment offset (low 6 bits of byte 20, all of byte 21) are zero, TTL (byte 22) is non-zero, total length is at least 20 and at most frame length minus 18, and destination IP (bytes 30..33) equals my_ip. DF may be set.
- R6: The IPv4 header (bytes 14..33) must sum to 0xFFFF in 16-bit ones'-complement arithmetic.
- R7: The class is 2 (ICMP) when the base rules pass, protocol (byte 23) is 1, total length is at least 28, type is 8, code is 0, and the IP payload checksums to 0xFFFF. An odd final byte is padded with zero.
- R8: The class is 3 (UDP) when the base rules pass, protocol is 17, total length is at least 28, source port is at least 1024, the destination port hits the port table, and the UDP length is at most total length minus 20. The UDP checksum field is not examined.
- R9: Port table entry i resets to INIT_PORTS[16i+15:16i], or to BASE_PORT+i when that field is zero (default 801..808). A cfg_we write replaces an entry. An entry holding zero never matches. When several entries match, the lowest index wins.
- R10: verdict_vld is high for exactly the cycle after each accepted last byte. verdict_class encodes 0 drop, 1 ARP, 2 ICMP, 3 UDP. verdict_client is the table index for class 3 and zero otherwise.
- R11: A start byte that arrives while a frame is open discards that frame with no strobe. Bytes outside a frame are ignored, even when their end marker is set.
- R12: After reset no strobe is raised until a frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Receive byte |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame (FCS included) |
| my_mac | input | 48 | Node MAC, first transmitted byte in bits 47:40 |
| my_ip | input | 32 | Node IPv4 address, first byte in bits 31:24 |
| cfg_we | input | 1 | Port table write enable |
| cfg_idx | input | CLIENT_W | Port table entry to write |
| cfg_port | input | 16 | New port value |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_class | output | 2 | 0 drop, 1 ARP, 2 ICMP, 3 UDP |
| verdict_client | output | CLIENT_W | Matching table index for UDP |

## Verification
Every verdict is due in the first cycle after the clock edge that samples the last byte. Earlier bytes go only into registered state, while the CRC residue compare covers the last byte without a register in between. The bench drives each byte on a falling edge. It records on each rising edge whether a last byte was taken, and on the following falling edge it requires any strobe to line up with that record. A scoreboard queue holds one expected class and index per complete frame, so frames that are aborted or stray bytes must produce nothing. The queue must be empty once the run has drained.

// File: rtl/frame_screen_pkg.sv
package frame_screen_pkg;

    typedef enum logic [1:0] {
        CLS_DROP = 2'd0,
        CLS_ARP  = 2'd1,
        CLS_ICMP = 2'd2,
        CLS_UDP  = 2'd3
    } verdict_cls_e;

    localparam logic [15:0] ETH_TYPE_ARP  = 16'h0806;
    localparam logic [15:0] ETH_TYPE_IPV4 = 16'h0800;
    localparam logic [31:0] CRC_POLY_REV  = 32'hEDB88320;
    localparam logic [31:0] CRC_GOOD_REM  = 32'hDEBB20E3;

    // One byte of the reflected CRC32, least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
        end
        return c;
    endfunction

    // 16-bit ones'-complement add with end-around carry.
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'h0, s[16]};
    endfunction

endpackage

// File: rtl/fs_crc32.sv
module fs_crc32
    import frame_screen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       en,
    input  logic [7:0] din,
    output logic       residue_ok
);
    logic [31:0] crc_d, crc_q;
    logic [31:0] seed, stepped;

    always_comb begin
        seed    = restart ? 32'hFFFF_FFFF : crc_q;
        stepped = crc_step(seed, din);
        crc_d   = en ? stepped : crc_q;
    end

    // Residue including the byte presented this cycle.
    assign residue_ok = (stepped == CRC_GOOD_REM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 32'hFFFF_FFFF;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/fs_csum16.sv
module fs_csum16
    import frame_screen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       hi_half,
    input  logic [7:0] din,
    output logic       sum_ok
);
    typedef struct packed {
        logic [15:0] acc;
        logic [7:0]  hold;
        logic        pend;
    } sum_st_t;

    sum_st_t s_d, s_q;
    logic [15:0] final_sum;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (en) begin
            if (hi_half) begin
                s_d.hold = din;
                s_d.pend = 1'b1;
            end else begin
                s_d.acc  = oc_add(s_q.acc, {s_q.hold, din});
                s_d.pend = 1'b0;
            end
        end
        // An odd trailing byte counts as a word with a zero low half.
        final_sum = s_q.pend ? oc_add(s_q.acc, {s_q.hold, 8'h00}) : s_q.acc;
    end

    assign sum_ok = (final_sum == 16'hFFFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fs_port_table.sv
module fs_port_table #(
    parameter int                       N_CLIENTS  = 8,
    parameter int                       BASE_PORT  = 801,
    parameter logic [16*N_CLIENTS-1:0]  INIT_PORTS = '0,
    localparam int                      IDX_W      = $clog2(N_CLIENTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [15:0]      cfg_port,
    input  logic [15:0]      lookup,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    logic [15:0] port_q [N_CLIENTS];
    logic [15:0] port_d [N_CLIENTS];

    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_entry
        localparam logic [15:0] RST_VAL = (INIT_PORTS[16*i +: 16] != 16'h0)
                                          ? INIT_PORTS[16*i +: 16]
                                          : 16'(BASE_PORT + i);
        always_comb begin
            port_d[i] = port_q[i];
            if (cfg_we && (cfg_idx == IDX_W'(i))) port_d[i] = cfg_port;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) port_q[i] <= RST_VAL;
            else        port_q[i] <= port_d[i];
        end
    end

    // Scan from the top so the lowest matching index is left standing.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_CLIENTS - 1; i >= 0; i--) begin
            if ((port_q[i] != 16'h0) && (port_q[i] == lookup)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/frame_screen.sv
module frame_screen
    import frame_screen_pkg::*;
#(
    parameter int                       N_CLIENTS  = 8,
    parameter int                       BASE_PORT  = 801,
    parameter logic [16*N_CLIENTS-1:0]  INIT_PORTS = '0,
    parameter int                       MAX_FRAME  = 1536,
    localparam int                      CLIENT_W   = $clog2(N_CLIENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          rx_data,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic [47:0]         my_mac,
    input  logic [31:0]         my_ip,
    input  logic                cfg_we,
    input  logic [CLIENT_W-1:0] cfg_idx,
    input  logic [15:0]         cfg_port,
    output logic                verdict_vld,
    output logic [1:0]          verdict_class,
    output logic [CLIENT_W-1:0] verdict_client
);
    localparam int POS_W = $clog2(MAX_FRAME + 1) + 1;

    typedef struct packed {
        logic                in_frame;
        logic [POS_W-1:0]    pos;
        logic [7:0]          prev;
        logic                src_mc;
        logic [15:0]         etype;
        logic                arp_ok;
        logic                ip_ok;
        logic                icmp_ok;
        logic [15:0]         ip_len;
        logic [7:0]          proto;
        logic [15:0]         sport;
        logic [15:0]         dport;
        logic [15:0]         ulen;
        logic                vld;
        verdict_cls_e        cls;
        logic [CLIENT_W-1:0] client;
    } scan_st_t;

    scan_st_t s_d, s_q;

    logic             take;
    logic [POS_W-1:0] off;
    int unsigned      off_i, len_i, ipl_i;
    logic [15:0]      cur16;
    logic [7:0]       mac_b, ip_b30, ip_b38;
    logic             hdr_en, pay_en, hi_half;
    logic             crc_ok, hdr_ok, pay_ok;
    logic             port_hit;
    logic [CLIENT_W-1:0] port_idx;
    logic             ip_base, is_arp, is_icmp, is_udp, frame_ok;

    assign take    = rx_valid && (rx_sof || s_q.in_frame);
    assign off     = rx_sof ? '0 : s_q.pos;
    assign off_i   = 32'(off);
    assign cur16   = {s_q.prev, rx_data};
    assign hi_half = ~off[0];
    assign hdr_en  = take && !rx_sof && (off_i >= 14) && (off_i <= 33);
    assign pay_en  = take && !rx_sof && (off_i >= 34) && (off_i < 14 + 32'(s_q.ip_len));

    // Address bytes that the current offset has to match.
    always_comb begin
        mac_b  = 8'h00;
        ip_b30 = 8'h00;
        ip_b38 = 8'h00;
        for (int k = 0; k < 6; k++) begin
            if (off_i == k) mac_b = my_mac[47-8*k -: 8];
        end
        for (int k = 0; k < 4; k++) begin
            if (off_i == 30 + k) ip_b30 = my_ip[31-8*k -: 8];
            if (off_i == 38 + k) ip_b38 = my_ip[31-8*k -: 8];
        end
    end

    fs_crc32 u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (rx_sof),
        .en         (take),
        .din        (rx_data),
        .residue_ok (crc_ok)
    );

    fs_csum16 u_hdr_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take && rx_sof),
        .en      (hdr_en),
        .hi_half (hi_half),
        .din     (rx_data),
        .sum_ok  (hdr_ok)
    );

    fs_csum16 u_pay_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take && rx_sof),
        .en      (pay_en),
        .hi_half (hi_half),
        .din     (rx_data),
        .sum_ok  (pay_ok)
    );

    fs_port_table #(
        .N_CLIENTS  (N_CLIENTS),
        .BASE_PORT  (BASE_PORT),
        .INIT_PORTS (INIT_PORTS)
    ) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_port (cfg_port),
        .lookup   (s_q.dport),
        .hit      (port_hit),
        .hit_idx  (port_idx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.vld    = 1'b0;
        s_d.cls    = CLS_DROP;
        s_d.client = '0;
        len_i      = off_i + 1;
        ipl_i      = 0;
        ip_base    = 1'b0;
        is_arp     = 1'b0;
        is_icmp    = 1'b0;
        is_udp     = 1'b0;
        frame_ok   = 1'b0;

        if (take) begin
            if (rx_sof) begin
                s_d.src_mc  = 1'b0;
                s_d.etype   = '0;
                s_d.arp_ok  = 1'b1;
                s_d.ip_ok   = 1'b1;
                s_d.icmp_ok = 1'b1;
                s_d.ip_len  = '0;
                s_d.proto   = '0;
                s_d.sport   = '0;
                s_d.dport   = '0;
                s_d.ulen    = '0;
            end
            s_d.in_frame = !rx_eof;
            s_d.pos      = (&off) ? off : off + 1'b1;
            s_d.prev     = rx_data;

            if (off_i < 6 && rx_data != mac_b)                   s_d.ip_ok  = 1'b0;
            if (off_i >= 30 && off_i <= 33 && rx_data != ip_b30) s_d.ip_ok  = 1'b0;
            if (off_i >= 38 && off_i <= 41 && rx_data != ip_b38) s_d.arp_ok = 1'b0;

            case (off_i)
                6:  s_d.src_mc = rx_data[0];
                13: s_d.etype  = cur16;
                14: if (rx_data != 8'h45) s_d.ip_ok = 1'b0;
                15: if (cur16 != 16'h0001) s_d.arp_ok = 1'b0;
                17: begin
                    s_d.ip_len = cur16;
                    if (cur16 != ETH_TYPE_IPV4) s_d.arp_ok = 1'b0;
                end
                18: if (rx_data != 8'd6) s_d.arp_ok = 1'b0;
                19: if (rx_data != 8'd4) s_d.arp_ok = 1'b0;
                21: begin
                    if (cur16 != 16'h0001) s_d.arp_ok = 1'b0;
                    if (s_q.prev[5:0] != 6'h0 || rx_data != 8'h00) s_d.ip_ok = 1'b0;
                end
                22: if (rx_data == 8'h00) s_d.ip_ok = 1'b0;
                23: s_d.proto = rx_data;
                34: if (rx_data != 8'd8) s_d.icmp_ok = 1'b0;
                35: begin
                    s_d.sport = cur16;
                    if (rx_data != 8'd0) s_d.icmp_ok = 1'b0;
                end
                37: s_d.dport = cur16;
                39: s_d.ulen  = cur16;
                default: ;
            endcase

            if (rx_eof) begin
                ipl_i    = 32'(s_d.ip_len);
                frame_ok = crc_ok && !s_d.src_mc && (len_i <= MAX_FRAME);
                is_arp   = (s_d.etype == ETH_TYPE_ARP) && s_d.arp_ok && (len_i >= 46);
                ip_base  = (s_d.etype == ETH_TYPE_IPV4) && s_d.ip_ok && hdr_ok &&
                           (ipl_i >= 20) && (ipl_i + 18 <= len_i);
                is_icmp  = ip_base && (s_d.proto == 8'd1) && (ipl_i >= 28) &&
                           s_d.icmp_ok && pay_ok;
                is_udp   = ip_base && (s_d.proto == 8'd17) && (ipl_i >= 28) &&
                           (s_d.sport >= 16'd1024) && port_hit &&
                           (32'(s_d.ulen) <= ipl_i - 20);
                s_d.vld  = 1'b1;
                if (frame_ok) begin
                    if (is_arp) begin
                        s_d.cls = CLS_ARP;
                    end else if (is_icmp) begin
                        s_d.cls = CLS_ICMP;
                    end else if (is_udp) begin
                        s_d.cls    = CLS_UDP;
                        s_d.client = port_idx;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cls <= CLS_DROP;
        end else begin
            s_q <= s_d;
        end
    end

    assign verdict_vld    = s_q.vld;
    assign verdict_class  = s_q.cls;
    assign verdict_client = s_q.client;
endmodule

// File: rtl/frame_screen_chk.sv
module frame_screen_chk #(
    parameter int CLIENT_W  = 3,
    parameter int MAX_FRAME = 1536
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic                rx_sof,
    input logic                rx_eof,
    input logic                src_bit,
    input logic                verdict_vld,
    input logic [1:0]          verdict_class,
    input logic [CLIENT_W-1:0] verdict_client
);
    logic        in_q, eof_q, mc_cur_q, mc_q;
    logic [12:0] cnt_q, len_q;
    logic        take;
    logic [12:0] cnt_n;

    assign take  = rx_valid && (rx_sof || in_q);
    assign cnt_n = rx_sof ? 13'd1 : ((&cnt_q) ? cnt_q : cnt_q + 13'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= 1'b0; eof_q <= 1'b0; mc_cur_q <= 1'b0; mc_q <= 1'b0;
            cnt_q <= '0; len_q <= '0;
        end else begin
            eof_q <= take && rx_eof;
            if (take) begin
                in_q  <= !rx_eof;
                cnt_q <= cnt_n;
                if (rx_sof) mc_cur_q <= 1'b0;
                if (cnt_n == 13'd7) mc_cur_q <= src_bit;
                if (rx_eof) begin
                    len_q <= cnt_n;
                    mc_q  <= (cnt_n == 13'd7) ? src_bit : (rx_sof ? 1'b0 : mc_cur_q);
                end
            end
        end
    end

    // R10
    strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld == eof_q);
    // R10
    client_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_vld && verdict_class != 2'd3) |-> (verdict_client == '0));
    // R2
    max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_vld && verdict_class != 2'd0) |-> (32'(len_q) <= MAX_FRAME));
    // R3
    src_unicast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_vld && verdict_class != 2'd0) |-> !mc_q);
    // R4
    arp_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_vld && verdict_class == 2'd1) |-> (len_q >= 13'd46));
endmodule

bind frame_screen frame_screen_chk #(
    .CLIENT_W  (CLIENT_W),
    .MAX_FRAME (MAX_FRAME)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .rx_sof         (rx_sof),
    .rx_eof         (rx_eof),
    .src_bit        (rx_data[0]),
    .verdict_vld    (verdict_vld),
    .verdict_class  (verdict_class),
    .verdict_client (verdict_client)
);

// File: tb/frame_screen_bench.sv
`timescale 1ns/1ps
module frame_screen_bench;
    localparam logic [47:0] MY_MAC   = 48'h02_00_00_AB_CD_EF;
    localparam logic [31:0] MY_IP    = 32'hC0_A8_07_04;
    localparam logic [47:0] PEER_MAC = 48'h0A_11_22_33_44_55;
    localparam logic [31:0] PEER_IP  = 32'hC0_A8_07_01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [15:0] cfg_port = 16'd0;
    logic        verdict_vld;
    logic [1:0]  verdict_class;
    logic [2:0]  verdict_client;

    frame_screen u_frame_screen (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .my_mac(MY_MAC), .my_ip(MY_IP),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_port(cfg_port),
        .verdict_vld(verdict_vld), .verdict_class(verdict_class),
        .verdict_client(verdict_client)
    );

    int    checks = 0, errors = 0;
    bit    done = 0;
    int    exp_q[$];
    string tag_q[$];
    logic [7:0] fb[$];
    logic  eof_taken = 1'b0;

    always @(posedge clk) eof_taken <= rx_valid && rx_eof;

    // Monitor: scoreboard pop and compare.
    always @(negedge clk) begin
        if (rst_n && verdict_vld) begin
            checks++;
            if (!eof_taken) begin
                errors++;
                $display("FAIL R10 strobe timing: eof_taken=%0d expected 1", eof_taken);
            end
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected verdict class %0d client %0d, expected none",
                         verdict_class, verdict_client);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({29'd0, verdict_class, verdict_client} != e) begin
                    errors++;
                    $display("FAIL %s: class %0d client %0d, expected class %0d client %0d",
                             t, verdict_class, verdict_client, e / 8, e % 8);
                end
            end
        end
    end

    function automatic void put16(input int v);
        fb.push_back(v[15:8]);
        fb.push_back(v[7:0]);
    endfunction

    function automatic void put_mac(input logic [47:0] m);
        for (int k = 0; k < 6; k++) fb.push_back(m[47-8*k -: 8]);
    endfunction

    function automatic void put_ip(input logic [31:0] a);
        for (int k = 0; k < 4; k++) fb.push_back(a[31-8*k -: 8]);
    endfunction

    function automatic logic [15:0] ocsum(input int start, input int n);
        int unsigned s = 0;
        for (int i = 0; i < n; i += 2) begin
            s += {fb[start+i], (i + 1 < n) ? fb[start+i+1] : 8'h00};
        end
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        return ~s[15:0];
    endfunction

    function automatic void mk_arp(input logic [31:0] tpa, input int oper);
        fb.delete();
        put_mac(48'hFF_FF_FF_FF_FF_FF); put_mac(PEER_MAC); put16(16'h0806);
        put16(1); put16(16'h0800); fb.push_back(8'd6); fb.push_back(8'd4); put16(oper);
        put_mac(PEER_MAC); put_ip(PEER_IP); put_mac(48'h0); put_ip(tpa);
    endfunction

    function automatic void mk_ip_hdr(input int tot, input int proto);
        fb.delete();
        put_mac(MY_MAC); put_mac(PEER_MAC); put16(16'h0800);
        fb.push_back(8'h45); fb.push_back(8'h00); put16(tot); put16(16'h1234);
        put16(16'h0000); fb.push_back(8'd64); fb.push_back(proto[7:0]); put16(0);
        put_ip(PEER_IP); put_ip(MY_IP);
    endfunction

    function automatic void mk_icmp(input int npay);
        mk_ip_hdr(28 + npay, 1);
        fb.push_back(8'd8); fb.push_back(8'd0); put16(0); put16(16'h0007); put16(16'h0001);
        for (int i = 0; i < npay; i++) fb.push_back(8'(i * 7 + 3));
    endfunction

    function automatic void mk_udp(input int sport, input int dport, input int npay, input int ulen_adj);
        mk_ip_hdr(28 + npay, 17);
        put16(sport); put16(dport); put16(8 + npay + ulen_adj); put16(16'hBEEF);
        for (int i = 0; i < npay; i++) fb.push_back(8'(i + 1));
    endfunction

    // Fill checksums, add padding and the FCS.
    function automatic void seal(input int pad, input bit bad_ip, input bit bad_l4, input bit bad_crc);
        logic [15:0] c16;
        logic [31:0] c;
        int          tot;
        if (fb.size() >= 34 && {fb[12], fb[13]} == 16'h0800) begin
            c16 = ocsum(14, 20) ^ (bad_ip ? 16'h0001 : 16'h0000);
            fb[24] = c16[15:8]; fb[25] = c16[7:0];
            tot = {fb[16], fb[17]};
            if (fb[23] == 8'd1) begin
                c16 = ocsum(34, tot - 20) ^ (bad_l4 ? 16'h0100 : 16'h0000);
                fb[36] = c16[15:8]; fb[37] = c16[7:0];
            end
        end
        for (int i = 0; i < pad; i++) fb.push_back(8'h00);
        c = 32'hFFFF_FFFF;
        foreach (fb[i]) begin
            c ^= {24'h0, fb[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        if (bad_crc) c ^= 32'h0000_0100;
        fb.push_back(c[7:0]); fb.push_back(c[15:8]); fb.push_back(c[23:16]); fb.push_back(c[31:24]);
    endfunction

    task automatic put_byte(input logic [7:0] b, input logic sof, input logic eof);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_sof = sof; rx_eof = eof;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        end
    endtask

    task automatic send(input int cls, input int cli, input string tag);
        exp_q.push_back(cls * 8 + cli);
        tag_q.push_back(tag);
        foreach (fb[i]) put_byte(fb[i], i == 0, i == fb.size() - 1);
        idle(3);
    endtask

    task automatic cfg_write(input int idx, input int port);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_port = 16'(port);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (verdict_vld !== 1'b0 || verdict_class !== 2'd0) begin
            errors++;
            $display("FAIL R12 reset: vld %0d class %0d, expected 0 0", verdict_vld, verdict_class);
        end
        rst_n = 1'b1;
        idle(3);
        checks++;
        if (verdict_vld !== 1'b0) begin
            errors++;
            $display("FAIL R12 idle after reset: vld %0d, expected 0", verdict_vld);
        end

        // ARP
        mk_arp(MY_IP, 1);            seal(0, 0, 0, 0); send(1, 0, "R4/R2 ARP request, no padding");
        mk_arp(MY_IP ^ 32'h1, 1);    seal(0, 0, 0, 0); send(0, 0, "R4 ARP foreign target");
        mk_arp(MY_IP, 2);            seal(0, 0, 0, 0); send(0, 0, "R4 ARP reply opcode");
        mk_arp(MY_IP, 1); fb[18] = 8'd8; seal(0, 0, 0, 0); send(0, 0, "R4 ARP hw length 8");

        // ICMP
        mk_icmp(5);                  seal(0, 0, 0, 0); send(2, 0, "R7 ICMP echo odd payload");
        mk_icmp(6);                  seal(0, 0, 1, 0); send(0, 0, "R7 ICMP bad checksum");
        mk_icmp(6); fb[34] = 8'd0;   seal(0, 0, 0, 0); send(0, 0, "R7 ICMP type 0");
        mk_icmp(6);                  seal(0, 1, 0, 0); send(0, 0, "R6 IP header checksum");
        mk_icmp(6); fb[22] = 8'd0;   seal(0, 0, 0, 0); send(0, 0, "R5 TTL zero");
        mk_icmp(6); fb[20] = 8'h20;  seal(0, 0, 0, 0); send(0, 0, "R5 MF set");
        mk_icmp(6); fb[21] = 8'h01;  seal(0, 0, 0, 0); send(0, 0, "R5 fragment offset");
        mk_icmp(6); fb[20] = 8'h40;  seal(0, 0, 0, 0); send(2, 0, "R5 DF allowed");
        mk_icmp(6); fb[14] = 8'h46;  seal(0, 0, 0, 0); send(0, 0, "R5 header length 6");
        mk_icmp(6); fb[5] = 8'hEE;   seal(0, 0, 0, 0); send(0, 0, "R5 foreign dest MAC");
        mk_icmp(6); fb[33] = 8'h05;  seal(0, 0, 0, 0); send(0, 0, "R5 foreign dest IP");
        mk_icmp(6); fb[6] = 8'h0B;   seal(0, 0, 0, 0); send(0, 0, "R3 multicast source");
        mk_icmp(6);                  seal(0, 0, 0, 1); send(0, 0, "R1 bad FCS");

        // UDP
        mk_udp(5000, 803, 8, 0);     seal(0, 0, 0, 0); send(3, 2, "R8/R9 UDP default port 803");
        mk_udp(1023, 801, 8, 0);     seal(0, 0, 0, 0); send(0, 0, "R8 source port 1023");
        mk_udp(1024, 808, 8, 0);     seal(0, 0, 0, 0); send(3, 7, "R8 source port 1024");
        mk_udp(5000, 900, 8, 0);     seal(0, 0, 0, 0); send(0, 0, "R8 unmatched port");
        mk_udp(5000, 801, 8, 1);     seal(0, 0, 0, 0); send(0, 0, "R8 UDP length too long");
        mk_udp(5000, 801, 8, 0); fb[17] = 8'd60; seal(0, 0, 0, 0); send(0, 0, "R5 IP length beyond frame");
        mk_udp(5000, 801, 8, 0);     seal(1482, 0, 0, 0); send(3, 0, "R2 length 1536");
        mk_udp(5000, 801, 8, 0);     seal(1483, 0, 0, 0); send(0, 0, "R2 length 1537");

        // Port table writes
        cfg_write(5, 4000);
        mk_udp(5000, 4000, 4, 0);    seal(0, 0, 0, 0); send(3, 5, "R9 rewritten entry");
        mk_udp(5000, 806, 4, 0);     seal(0, 0, 0, 0); send(0, 0, "R9 old port gone");
        cfg_write(6, 803);
        mk_udp(5000, 803, 4, 0);     seal(0, 0, 0, 0); send(3, 2, "R9 lowest index wins");
        cfg_write(0, 0);
        mk_udp(5000, 0, 4, 0);       seal(0, 0, 0, 0); send(0, 0, "R9 zero entry never matches");

        // Abort and stray bytes
        mk_arp(MY_IP, 1); seal(0, 0, 0, 0);
        for (int i = 0; i < 20; i++) put_byte(fb[i], i == 0, 1'b0);
        send(1, 0, "R11 restart discards open frame");
        for (int i = 0; i < 4; i++) put_byte(8'h55, 1'b0, i == 3);
        idle(4);
        put_byte(8'h00, 1'b1, 1'b1);
        exp_q.push_back(0); tag_q.push_back("R10 single byte frame");
        idle(3);
        mk_icmp(2);                  seal(0, 0, 0, 0); send(2, 0, "R11 frame after stray bytes");

        idle(5);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 missing verdicts: %0d pending, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule